// File: doc/BRIEF.md
# Dual-Window Channel Glitch Detector

This block sits between the input comparators of a timing capture path and its trace memories. It runs on a fast oversampling clock and sees every channel on every tick. A separate strobe marks the first tick of each sample period. Per channel, it counts level changes inside a detection window. A window covers one sample period and also reaches a fixed number of ticks into the next period. Two detector banks take the windows in turn, so the overlap stretch of one window runs while the other bank has already opened the next window. The counting therefore does not depend on how far apart the strobes are.

When a window closes, the block produces one write record. The record holds the channel values captured at the strobe tick, a write address that counts up for each record, and a glitch flag for each channel. The flags go to a memory of their own at the same address as the sample, on the same clock. Trigger logic can use them on that clock as well. With glitch mode off, all channels are stored as timing data and no flags are written. With glitch mode on, the upper half of the channels is given up. Only the lower half keeps timing data, and the storage that the upper half used now holds the lower half's glitch information.

Strobes must be at least OVL+1 ticks apart. OVL is the overlap in ticks.

Top module: `glitch_catcher`

## Requirements
- R1: After reset, wr_en, gl_we and gl_flag are 0, and the first record after reset is written at address 0.
- R2: A strobe on tick S opens the window for that sample period. If the next strobe comes on tick S', the window closes on tick S'+OVL-1. Exactly one record is written per window, with wr_en high for the single cycle after the closing tick. No record is written before the second strobe after reset.
- R3: The low NCH/2 bits of wr_data hold ch_in[NCH/2-1:0] as it was on the window's opening strobe tick.
- R4: A transition is a change of a channel between two consecutive ticks, and it counts on the later tick. Ticks from the opening tick through the closing tick count, including the overlap ticks. The very first tick after reset has no transition. If a lower-half channel has two or more transitions in a window, that window reports a glitch on that channel.
- R5: A window in which a channel has at most one transition reports no glitch on that channel.
- R6: The glitch flag of a record is the OR of the current window's result and the previous window's result. Both windows overlap that sample.
- R7: The glitch_en value on the closing tick sets the mode. When it is 1, wr_data[NCH-1:NCH/2] is 0, gl_we pulses together with wr_en, and gl_flag carries the flags of channels 0..NCH/2-1. When it is 0, wr_data[NCH-1:NCH/2] holds the upper channels from the opening tick, and gl_we and gl_flag stay 0.
- R8: The write address goes up by one for each record and wraps from 2^AW-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_in | input | NCH | Channel levels for this tick |
| smp_stb | input | 1 | High on the first tick of a sample period |
| glitch_en | input | 1 | Glitch mode: trades the upper half of the channels for glitch storage |
| wr_en | output | 1 | Timing data write strobe |
| wr_addr | output | AW | Address shared by the data write and the glitch write |
| wr_data | output | NCH | Timing data word |
| gl_we | output | 1 | Glitch memory write strobe |
| gl_flag | output | NCH/2 | Per-channel glitch flags, for the glitch memory and the trigger |

## Verification
The bench builds the block with NCH=8, OVL=2 and AW=4. The four-bit address wraps after sixteen records, so the wrap shows up many times within a short run. With only four detected channels, random toggling often lands two edges in one window on one channel, so pulses and single edges both occur many times. Two ticks of overlap against strobe spacings of three to eight ticks put transitions inside the overlap stretch often. Those transitions must count in two neighbouring windows.

// File: rtl/gd_pkg.sv
package gd_pkg;

    // Saturating transition count per channel: 0, 1, or 2 (= glitch)
    typedef logic [1:0] tcnt_t;

    localparam tcnt_t TCNT_GLITCH = 2'd2;

    // Identity of one of the two alternating detector banks
    typedef enum logic {
        DET_A = 1'b0,
        DET_B = 1'b1
    } det_id_e;

    function automatic tcnt_t tcnt_bump(input tcnt_t c, input logic e);
        if (e && (c != TCNT_GLITCH)) begin
            return c + 2'd1;
        end
        return c;
    endfunction

    function automatic det_id_e det_other(input det_id_e d);
        return (d == DET_A) ? DET_B : DET_A;
    endfunction

endpackage

// File: rtl/gd_edge_tap.sv
module gd_edge_tap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] edges
);
    logic [W-1:0] prev_q;
    logic         primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= din;
            primed_q <= 1'b1;
        end
    end

    // No history on the first tick after reset: report no change
    assign edges = primed_q ? (din ^ prev_q) : '0;

endmodule

// File: rtl/gd_sequencer.sv
module gd_sequencer
    import gd_pkg::*;
#(
    parameter int OVL = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    output logic [1:0] start_v,
    output logic [1:0] close_v
);
    localparam int AGEW = $clog2(OVL + 2);
    localparam logic [AGEW-1:0] AGE_MAX   = '1;
    localparam logic [AGEW-1:0] AGE_CLOSE = AGEW'(OVL - 1);

    logic [AGEW-1:0] age_q;
    logic [AGEW-1:0] cur_age;
    det_id_e         newest_q;
    logic [1:0]      seen_q;
    logic            closing;
    det_id_e         open_id;
    det_id_e         close_id;

    assign cur_age  = stb ? '0 : age_q;
    assign open_id  = det_other(newest_q);
    // With a strobe this tick the bank still listed as newest is the older one
    assign close_id = stb ? newest_q : det_other(newest_q);
    assign closing  = (cur_age == AGE_CLOSE) &&
                      (stb ? (seen_q != 2'd0) : (seen_q == 2'd2));

    always_comb begin
        start_v = '0;
        close_v = '0;
        if (stb) begin
            start_v[open_id] = 1'b1;
        end
        if (closing) begin
            close_v[close_id] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q    <= AGE_MAX;
            newest_q <= DET_B;
            seen_q   <= 2'd0;
        end else begin
            if (stb) begin
                age_q    <= AGEW'(1);
                newest_q <= open_id;
                if (seen_q != 2'd2) begin
                    seen_q <= seen_q + 2'd1;
                end
            end else if (age_q != AGE_MAX) begin
                age_q <= age_q + AGEW'(1);
            end
        end
    end

endmodule

// File: rtl/gd_window.sv
module gd_window
    import gd_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [W-1:0]  edges,
    input  logic [DW-1:0] din,
    output logic [W-1:0]  hit,
    output logic [DW-1:0] snap
);
    tcnt_t cnt_q [W];

    for (genvar i = 0; i < W; i++) begin : g_ch
        tcnt_t nxt;
        assign nxt    = tcnt_bump(start ? '0 : cnt_q[i], edges[i]);
        // Result including the edge on the closing tick itself
        assign hit[i] = (nxt == TCNT_GLITCH);

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[i] <= '0;
            end else begin
                cnt_q[i] <= nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (start) begin
            snap <= din;
        end
    end

endmodule

// File: rtl/glitch_catcher.sv
module glitch_catcher
    import gd_pkg::*;
#(
    parameter int NCH = 16,
    parameter int OVL = 2,
    parameter int AW  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ch_in,
    input  logic              smp_stb,
    input  logic              glitch_en,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [NCH-1:0]    wr_data,
    output logic              gl_we,
    output logic [NCH/2-1:0]  gl_flag
);
    localparam int HALF = NCH / 2;

    logic [HALF-1:0] edges;
    logic [1:0]      start_v;
    logic [1:0]      close_v;
    logic [HALF-1:0] hit_w  [2];
    logic [NCH-1:0]  snap_w [2];

    gd_edge_tap #(.W(HALF)) u_tap (
        .clk   (clk),
        .rst   (rst),
        .din   (ch_in[HALF-1:0]),
        .edges (edges)
    );

    gd_sequencer #(.OVL(OVL)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .stb     (smp_stb),
        .start_v (start_v),
        .close_v (close_v)
    );

    for (genvar g = 0; g < 2; g++) begin : g_det
        gd_window #(.W(HALF), .DW(NCH)) u_win (
            .clk   (clk),
            .rst   (rst),
            .start (start_v[g]),
            .edges (edges),
            .din   (ch_in),
            .hit   (hit_w[g]),
            .snap  (snap_w[g])
        );
    end

    logic            close_any;
    logic [HALF-1:0] sel_hit;
    logic [NCH-1:0]  sel_snap;
    logic [HALF-1:0] carry_q;
    logic [AW-1:0]   addr_q;

    assign close_any = |close_v;
    assign sel_hit   = close_v[DET_B] ? hit_w[DET_B]  : hit_w[DET_A];
    assign sel_snap  = close_v[DET_B] ? snap_w[DET_B] : snap_w[DET_A];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            gl_we   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            gl_flag <= '0;
            carry_q <= '0;
            addr_q  <= '0;
        end else begin
            wr_en <= close_any;
            gl_we <= close_any & glitch_en;
            if (close_any) begin
                carry_q <= sel_hit;
                wr_addr <= addr_q;
                addr_q  <= addr_q + AW'(1);
                if (glitch_en) begin
                    wr_data <= {{(NCH - HALF){1'b0}}, sel_snap[HALF-1:0]};
                    gl_flag <= sel_hit | carry_q;
                end else begin
                    wr_data <= sel_snap;
                    gl_flag <= '0;
                end
            end else begin
                gl_flag <= '0;
            end
        end
    end

endmodule

// File: rtl/gd_checker.sv
module gd_checker #(
    parameter int NCH = 16,
    parameter int AW  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             glitch_en,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [NCH-1:0]   wr_data,
    input logic             gl_we,
    input logic [NCH/2-1:0] gl_flag
);
    localparam int HALF = NCH / 2;

    logic [AW-1:0] exp_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_addr_q <= '0;
        end else if (wr_en) begin
            exp_addr_q <= exp_addr_q + AW'(1);
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_en && !gl_we && gl_flag == '0)); // R1

    AST_SINGLE_CYCLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R2

    AST_ADDR_SEQUENCE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr == exp_addr_q)); // R8

    AST_GLWE_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        gl_we |-> wr_en); // R7

    AST_GLWE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        gl_we |-> $past(glitch_en)); // R7

    AST_FLAG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !gl_we |-> (gl_flag == '0)); // R7

    AST_UPPER_DATA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        gl_we |-> (wr_data[NCH-1:HALF] == '0)); // R7

endmodule

bind glitch_catcher gd_checker #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .glitch_en (glitch_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .gl_we     (gl_we),
    .gl_flag   (gl_flag)
);

// File: tb/glitch_catcher_test.sv
`timescale 1ns/1ps
module glitch_catcher_test;
    localparam int NCH  = 8;
    localparam int OVL  = 2;
    localparam int AW   = 4;
    localparam int HALF = NCH / 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  ch_in = '0;
    logic            smp_stb = 1'b0;
    logic            glitch_en = 1'b1;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [NCH-1:0]  wr_data;
    logic            gl_we;
    logic [HALF-1:0] gl_flag;

    always #2.5 clk = ~clk;

    glitch_catcher #(.NCH(NCH), .OVL(OVL), .AW(AW)) uut (
        .clk(clk), .rst(rst), .ch_in(ch_in), .smp_stb(smp_stb),
        .glitch_en(glitch_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gl_we(gl_we), .gl_flag(gl_flag)
    );

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    int nstb   = 0;
    int wcnt   = 0;
    logic [NCH-1:0] cur = '0;
    logic [NCH-1:0] hist [0:8191];
    logic           en_hist [0:8191];
    int             stb_at [0:4095];

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at tick %0d: got %0h expected %0h", tag, t, act, exp);
        end
    endtask

    function automatic logic [HALF-1:0] win_hit(input int n);
        logic [HALF-1:0] h = '0;
        int cnt [HALF];
        for (int c = 0; c < HALF; c++) cnt[c] = 0;
        for (int k = stb_at[n]; k <= stb_at[n+1] + OVL - 1; k++) begin
            if (k >= 1) begin
                for (int c = 0; c < HALF; c++) begin
                    if (hist[k][c] != hist[k-1][c]) cnt[c]++;
                end
            end
        end
        for (int c = 0; c < HALF; c++) h[c] = (cnt[c] >= 2);
        return h;
    endfunction

    task automatic check_tick();
        logic expw;
        expw = (nstb >= 2) && (t - stb_at[nstb-1] == OVL - 1);
        chk(wr_en == expw, "R2", 32'(wr_en), 32'(expw));
        if (expw) begin
            int n;
            logic [HALF-1:0] h, hp, fl, expf;
            logic [NCH-1:0] d;
            logic e;
            string ftag;
            n  = nstb - 2;
            h  = win_hit(n);
            hp = (n >= 1) ? win_hit(n - 1) : '0;
            fl = h | hp;
            d  = hist[stb_at[n]];
            e  = en_hist[t];
            chk(wr_addr == AW'(wcnt), (wcnt == 0) ? "R1" : "R8",
                32'(wr_addr), 32'(AW'(wcnt)));
            wcnt++;
            chk(wr_data[HALF-1:0] == d[HALF-1:0], "R3",
                32'(wr_data[HALF-1:0]), 32'(d[HALF-1:0]));
            chk(wr_data[NCH-1:HALF] == (e ? '0 : d[NCH-1:HALF]), "R7",
                32'(wr_data[NCH-1:HALF]), 32'(e ? '0 : d[NCH-1:HALF]));
            chk(gl_we == e, "R7", 32'(gl_we), 32'(e));
            expf = e ? fl : '0;
            if (!e)                ftag = "R7";
            else if ((hp & ~h) != 0) ftag = "R6";
            else if (h != 0)       ftag = "R4";
            else                   ftag = "R5";
            chk(gl_flag == expf, ftag, 32'(gl_flag), 32'(expf));
        end else begin
            chk(gl_we == 1'b0, "R7", 32'(gl_we), 32'd0);
        end
    endtask

    task automatic step(input logic [NCH-1:0] v, input logic s, input logic e);
        ch_in = v; smp_stb = s; glitch_en = e;
        hist[t] = v; en_hist[t] = e;
        if (s) begin
            stb_at[nstb] = t;
            nstb++;
        end
        @(posedge clk);
        #1;
        check_tick();
        t++;
        @(negedge clk);
    endtask

    // One sample period: strobe on tick 0, optional toggles on ticks a and b
    task automatic run_period(input int len, input int a, input logic [NCH-1:0] ma,
                              input int b, input logic [NCH-1:0] mb, input logic e);
        for (int i = 0; i < len; i++) begin
            if (i == a) cur ^= ma;
            if (i == b) cur ^= mb;
            step(cur, i == 0, e);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        chk(wr_en == 1'b0, "R1", 32'(wr_en), 32'd0);
        chk(gl_we == 1'b0, "R1", 32'(gl_we), 32'd0);
        chk(gl_flag == '0, "R1", 32'(gl_flag), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed corner cases
        step(cur, 1'b0, 1'b1);
        step(cur, 1'b0, 1'b1);
        run_period(5, 99, '0, 99, '0, 1'b1);                  // quiet: R5
        run_period(5, 2, 8'h01, 99, '0, 1'b1);                // single edge: R5
        run_period(5, 1, 8'h02, 3, 8'h02, 1'b1);              // pulse: R4
        run_period(5, 99, '0, 99, '0, 1'b1);                  // carried flag: R6
        run_period(5, 99, '0, 99, '0, 1'b1);
        run_period(4, 3, 8'h04, 99, '0, 1'b1);                // edge at period end
        run_period(5, 0, 8'h04, 99, '0, 1'b1);                // second in overlap: R4
        run_period(5, 1, 8'h48, 2, 8'h08, 1'b0);              // mode off: R7
        run_period(5, 99, '0, 99, '0, 1'b0);
        run_period(3, 1, 8'hA0, 99, '0, 1'b1);                // shortest spacing
        run_period(3, 99, '0, 99, '0, 1'b1);

        // Constrained random periods
        begin
            logic e = 1'b1;
            for (int p = 0; p < 400; p++) begin
                int len;
                if (p % 20 == 0) e = ($urandom % 3) != 0;
                len = OVL + 1 + int'($urandom % 6);
                for (int i = 0; i < len; i++) begin
                    logic [NCH-1:0] m = '0;
                    for (int c = 0; c < NCH; c++) m[c] = ($urandom % 8) == 0;
                    cur ^= m;
                    step(cur, i == 0, e);
                end
            end
            // Flush the last open window
            step(cur, 1'b1, e);
            for (int i = 0; i < 3; i++) step(cur, 1'b0, e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule